// File: doc/BRIEF.md
# Oversampled Clock/Data Timing Monitor

This block watches two external lines, a monitored clock and a monitored data line. It samples both with a much faster system clock, so every interval is a count of system-clock cycles ("ticks"). Each line first goes through its own wire-delay stage and then through an inertial glitch filter. Only the filtered versions are checked. The block checks data setup and hold around every falling edge of the filtered monitored clock, and it checks the minimum duration of that clock's high and low phases.

Each violation produces a one-cycle report on the output. The report carries a kind code, the interval that was measured and the interval that was required, so a consumer can read "measured < required" straight from the fields. The block is meant to sit beside an interface in a verification or silicon-debug build, where a stream of violation reports is logged or counted elsewhere.

Top module: `edge_timing_monitor`

## Requirements
- R1: Each monitored input is delayed by its own parameter (`WD_CLK`, `WD_DAT`) before filtering. A change on an input reaches the checks wire-delay plus max(`SPIKE`,1) ticks later, so with default parameters the internal data path leads the internal clock path by 10 ticks.
- R2: A pulse on either input shorter than `SPIKE` ticks never reaches the checks and causes no report.
- R3: On a falling edge of the internal clock, a setup report (kind 0) is issued when internal data changed fewer than `T_SETUP` ticks before it. The measured value is the elapsed tick count, which is 0 if the change lands in the same tick as the edge.
- R4: Only the falling internal clock edge starts setup and hold checks. A data change near a rising edge raises nothing.
- R5: After each falling edge a hold window of `T_HOLD` ticks opens. The first internal data change k ticks into it, with k < `T_HOLD`, gives a hold report (kind 1, measured k) and closes the window, so any later change in the same window is ignored.
- R6: A high phase of the internal clock shorter than `T_HIGH` ticks gives kind 2, with the measured high width, when the phase ends.
- R7: A low phase of the internal clock shorter than `T_LOW` ticks gives kind 3, with the measured low width, when the phase ends.
- R8: A report is a single-cycle `viol_vld_o` pulse. `viol_kind_o` is 0 for setup, 1 for hold, 2 for high width and 3 for low width. `viol_req_o` equals the parameter for that kind, and `viol_meas_o` is always below it.
- R9: Violations found in the same tick are reported on consecutive cycles in ascending kind order. None is lost.
- R10: A timing parameter of zero disables its check entirely.
- R11: Interval counters saturate at 65535 instead of wrapping, so a very long quiet interval never reads as a short one.
- R12: During and after reset the outputs are zero. Interval counters start saturated, so the first phase after reset produces no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | 1 | Monitored clock line, sampled each tick |
| mon_dat_i | input | 1 | Monitored data line, sampled each tick |
| viol_vld_o | output | 1 | One-cycle strobe marking a violation report |
| viol_kind_o | output | 3 | Violation kind: 0 setup, 1 hold, 2 high width, 3 low width |
| viol_meas_o | output | 16 | Measured interval in ticks |
| viol_req_o | output | 16 | Required interval in ticks |

## Verification
A wrong filter or delay state changes the tick at which reports appear and the measured counts they carry, starting with the first edge after the fault. The reference model compares every cycle, so an offset of even one tick is caught at that report. A stuck or dropped hold window, or a wrapping counter, shows up as a missing, extra or wrong-valued report at the next falling edge or at the next change of data. A faulty pending queue in the arbiter shows up within a cycle or two of a multi-violation tick, as a report out of order, repeated or missing.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int MW = 16;   // measured/required field width
    localparam int KW = 3;    // kind code width
    localparam int NK = 4;    // number of violation kinds

    typedef enum logic [KW-1:0] {
        VK_SETUP = 3'd0,
        VK_HOLD  = 3'd1,
        VK_HIGH  = 3'd2,
        VK_LOW   = 3'd3
    } viol_kind_e;

    // one tick's worth of detected violations, indexed by kind code
    typedef struct packed {
        logic [NK-1:0]         hit;
        logic [NK-1:0][MW-1:0] meas;
    } viol_ev_t;

endpackage

// File: rtl/tmon_dlyfilt.sv
module tmon_dlyfilt #(
    parameter int DELAY = 0,
    parameter int SPIKE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int HOLD_N = (SPIKE < 1) ? 1 : SPIKE;
    localparam int CW     = $clog2(HOLD_N + 1);

    logic dly;

    generate
        if (DELAY == 0) begin : g_nodly
            assign dly = din;
        end else begin : g_dly
            logic [DELAY-1:0] sh_d, sh_q;
            always_comb sh_d = (sh_q << 1) | DELAY'(din);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end
            assign dly = sh_q[DELAY-1];
        end
    endgenerate

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (dly == flt_q.lvl) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(HOLD_N - 1)) begin
            flt_d.lvl = dly;
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign dout = flt_q.lvl;

    // R2: the filtered level only moves to a value the delayed line already held
    a_r2_follows_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(dly) == dout));

    generate
        if (HOLD_N >= 2) begin : g_spike_chk
            // R2: a change needs at least two stable ticks when filtering is on
            a_r2_two_stable: assert property (@(posedge clk) disable iff (!rst_n)
                (dout != $past(dout)) |-> ($past(dly, 2) == dout));
        end
    endgenerate

endmodule

// File: rtl/tmon_window.sv
module tmon_window
    import tmon_pkg::*;
#(
    parameter int T_SETUP = 0,
    parameter int T_HOLD  = 0,
    parameter int T_HIGH  = 0,
    parameter int T_LOW   = 0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ck,
    input  logic     dt,
    output viol_ev_t ev
);
    typedef struct packed {
        logic          cp;
        logic          dp;
        logic [MW-1:0] age;
        logic [MW-1:0] pw;
        logic [MW-1:0] hcnt;
        logic          hopen;
    } win_t;

    win_t st_d, st_q;
    logic fall, rise, dchg;
    logic [MW-1:0] su_el, pw_el, hk;

    function automatic logic [MW-1:0] sat_inc(input logic [MW-1:0] v);
        return (v == '1) ? v : v + MW'(1);
    endfunction

    always_comb begin
        fall  = st_q.cp & ~ck;
        rise  = ~st_q.cp & ck;
        dchg  = dt ^ st_q.dp;
        su_el = dchg ? '0 : sat_inc(st_q.age);
        pw_el = sat_inc(st_q.pw);
        hk    = sat_inc(st_q.hcnt);

        ev   = '0;
        st_d = st_q;

        if (T_SETUP > 0 && fall && su_el < MW'(T_SETUP)) begin
            ev.hit[VK_SETUP]  = 1'b1;
            ev.meas[VK_SETUP] = su_el;
        end
        if (T_HIGH > 0 && fall && pw_el < MW'(T_HIGH)) begin
            ev.hit[VK_HIGH]  = 1'b1;
            ev.meas[VK_HIGH] = pw_el;
        end
        if (T_LOW > 0 && rise && pw_el < MW'(T_LOW)) begin
            ev.hit[VK_LOW]  = 1'b1;
            ev.meas[VK_LOW] = pw_el;
        end

        if (st_q.hopen) begin
            st_d.hcnt = hk;
            if (dchg && hk < MW'(T_HOLD)) begin
                ev.hit[VK_HOLD]  = 1'b1;
                ev.meas[VK_HOLD] = hk;
                st_d.hopen       = 1'b0;
            end else if (hk >= MW'(T_HOLD)) begin
                st_d.hopen = 1'b0;
            end
        end
        if (T_HOLD > 0 && fall) begin
            st_d.hopen = 1'b1;
            st_d.hcnt  = '0;
        end

        st_d.cp  = ck;
        st_d.dp  = dt;
        st_d.age = dchg ? '0 : sat_inc(st_q.age);
        st_d.pw  = (fall | rise) ? '0 : pw_el;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.age   <= '1;
            st_q.pw    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: a saturated age stays saturated while data is quiet
    a_r11_age_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == '1 && dt == st_q.dp) |=> (st_q.age == '1));

    // R11: a saturated phase counter stays saturated between clock edges
    a_r11_width_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pw == '1 && ck == st_q.cp) |=> (st_q.pw == '1));

    generate
        if (T_HOLD > 0) begin : g_hold_chk
            // R5: an open hold window never outlives its length
            a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.hopen |-> (st_q.hcnt < MW'(T_HOLD)));
        end
    endgenerate

endmodule

// File: rtl/tmon_report.sv
module tmon_report
    import tmon_pkg::*;
#(
    parameter int T_SETUP = 0,
    parameter int T_HOLD  = 0,
    parameter int T_HIGH  = 0,
    parameter int T_LOW   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  viol_ev_t      ev,
    output logic          vld,
    output logic [KW-1:0] kind,
    output logic [MW-1:0] meas,
    output logic [MW-1:0] req
);
    localparam logic [NK-1:0][MW-1:0] REQS =
        {MW'(T_LOW), MW'(T_HIGH), MW'(T_HOLD), MW'(T_SETUP)};

    typedef struct packed {
        logic [NK-1:0]         pend;
        logic [NK-1:0][MW-1:0] pm;
        logic                  vld;
        logic [KW-1:0]         kind;
        logic [MW-1:0]         meas;
        logic [MW-1:0]         req;
    } rep_t;

    rep_t rp_d, rp_q;
    logic [NK-1:0]         all;
    logic [NK-1:0][MW-1:0] mv;
    logic [KW-1:0]         sel;

    always_comb begin
        all = rp_q.pend | ev.hit;
        for (int i = 0; i < NK; i++) begin
            mv[i] = ev.hit[i] ? ev.meas[i] : rp_q.pm[i];
        end
        sel = '0;
        for (int i = NK - 1; i >= 0; i--) begin
            if (all[i]) sel = KW'(i);
        end

        rp_d      = rp_q;
        rp_d.pm   = mv;
        rp_d.vld  = |all;
        rp_d.kind = sel;
        rp_d.meas = mv[sel[1:0]];
        rp_d.req  = REQS[sel[1:0]];
        rp_d.pend = all;
        if (|all) rp_d.pend[sel[1:0]] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign vld  = rp_q.vld;
    assign kind = rp_q.kind;
    assign meas = rp_q.meas;
    assign req  = rp_q.req;

    // R8: a report always shows measured below required
    a_r8_meas_below_req: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (meas < req));

    // R8: only the four defined codes appear
    a_r8_kind_range: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (kind < KW'(NK)));

    // R9: a detected violation is reported on the following cycle at the latest
    a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev.hit) |=> vld);

    // R9: a backlog keeps the report stream going
    a_r9_backlog_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_q.pend != '0) |=> vld);

endmodule

// File: rtl/edge_timing_monitor.sv
module edge_timing_monitor
    import tmon_pkg::*;
#(
    parameter int WD_CLK  = 20,
    parameter int WD_DAT  = 10,
    parameter int SPIKE   = 5,
    parameter int T_SETUP = 50,
    parameter int T_HOLD  = 75,
    parameter int T_HIGH  = 300,
    parameter int T_LOW   = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mon_clk_i,
    input  logic        mon_dat_i,
    output logic        viol_vld_o,
    output logic [2:0]  viol_kind_o,
    output logic [15:0] viol_meas_o,
    output logic [15:0] viol_req_o
);
    logic     ck_f, dt_f;
    viol_ev_t ev;

    tmon_dlyfilt #(.DELAY(WD_CLK), .SPIKE(SPIKE)) u_ck_path (
        .clk(clk), .rst_n(rst_n), .din(mon_clk_i), .dout(ck_f));

    tmon_dlyfilt #(.DELAY(WD_DAT), .SPIKE(SPIKE)) u_dt_path (
        .clk(clk), .rst_n(rst_n), .din(mon_dat_i), .dout(dt_f));

    tmon_window #(
        .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_HIGH(T_HIGH), .T_LOW(T_LOW)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .ck(ck_f), .dt(dt_f), .ev(ev));

    tmon_report #(
        .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_HIGH(T_HIGH), .T_LOW(T_LOW)
    ) u_report (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .vld(viol_vld_o), .kind(viol_kind_o),
        .meas(viol_meas_o), .req(viol_req_o));

    // R12: nothing is reported in the cycle reset is released
    a_r12_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !viol_vld_o);

endmodule

// File: tb/edge_timing_monitor_tb.sv
`timescale 1ns/1ps

module tmon_ref #(
    parameter int WD_C = 0, parameter int WD_D = 0, parameter int SP = 0,
    parameter int TSU = 0, parameter int THD = 0, parameter int THI = 0,
    parameter int TLO = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ck_raw,
    input  logic        dt_raw,
    output logic        vld,
    output logic [2:0]  kind,
    output logic [15:0] meas,
    output logic [15:0] req
);
    localparam int SEFF  = (SP < 1) ? 1 : SP;
    localparam int NEVER = -1000000;
    bit hc[$];
    bit hd[$];
    int n, cc, cd, last_chg, last_edge, hold_from;
    bit fc, fd, fc_old, fd_old, hold_on;
    bit pend[4];
    int pm[4];

    function automatic int capv(input int x);
        return (x > 65535) ? 65535 : x;
    endfunction

    function automatic int reqv(input int k);
        case (k)
            0: return TSU;
            1: return THD;
            2: return THI;
            default: return TLO;
        endcase
    endfunction

    function automatic bit delayed(ref bit h[$], input bit raw, input int d);
        if (d == 0) return raw;
        if (h.size() >= d) return h[h.size() - d];
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        bit ev[4];
        int em[4];
        bit all[4];
        int mm[4];
        bit fall, rise, dchg, dc, dd, found;
        int e, k, sel;
        if (!rst_n) begin
            hc.delete(); hd.delete();
            n = 0; cc = 0; cd = 0; last_chg = NEVER; last_edge = NEVER; hold_from = 0;
            fc = 0; fd = 0; fc_old = 0; fd_old = 0; hold_on = 0;
            for (int i = 0; i < 4; i++) begin pend[i] = 0; pm[i] = 0; end
            vld = 0; kind = 0; meas = 0; req = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin ev[i] = 0; em[i] = 0; end
            fall = fc_old && !fc;
            rise = !fc_old && fc;
            dchg = (fd != fd_old);
            if (fall && TSU > 0) begin
                e = dchg ? 0 : capv(n - last_chg);
                if (e < TSU) begin ev[0] = 1; em[0] = e; end
            end
            if (fall && THI > 0) begin
                e = capv(n - last_edge);
                if (e < THI) begin ev[2] = 1; em[2] = e; end
            end
            if (rise && TLO > 0) begin
                e = capv(n - last_edge);
                if (e < TLO) begin ev[3] = 1; em[3] = e; end
            end
            if (hold_on) begin
                k = n - hold_from;
                if (dchg && k < THD) begin ev[1] = 1; em[1] = k; hold_on = 0; end
                else if (k >= THD) hold_on = 0;
            end
            if (fall && THD > 0) begin hold_on = 1; hold_from = n; end
            if (dchg) last_chg = n;
            if (fall || rise) last_edge = n;
            found = 0; sel = 0;
            for (int i = 0; i < 4; i++) begin
                all[i] = pend[i] || ev[i];
                mm[i]  = ev[i] ? em[i] : pm[i];
                if (all[i] && !found) begin found = 1; sel = i; end
            end
            vld = found;
            kind = 3'(sel);
            meas = 16'(mm[sel]);
            req = 16'(reqv(sel));
            for (int i = 0; i < 4; i++) begin
                pend[i] = all[i] && !(found && i == sel);
                pm[i] = mm[i];
            end
            fc_old = fc; fd_old = fd;
            dc = delayed(hc, ck_raw, WD_C);
            dd = delayed(hd, dt_raw, WD_D);
            hc.push_back(ck_raw); hd.push_back(dt_raw);
            if (hc.size() > WD_C + 4) void'(hc.pop_front());
            if (hd.size() > WD_D + 4) void'(hd.pop_front());
            if (dc == fc) cc = 0;
            else if (cc + 1 >= SEFF) begin fc = dc; cc = 0; end
            else cc++;
            if (dd == fd) cd = 0;
            else if (cd + 1 >= SEFF) begin fd = dd; cd = 0; end
            else cd++;
            n++;
        end
    end
endmodule

module edge_timing_monitor_tb;
    logic clk = 0;
    logic rst_n = 0;
    logic tck = 0;
    logic tdat = 0;
    always #5 clk = ~clk;

    logic v0, v1, rv0, rv1;
    logic [2:0] k0, k1, rk0, rk1;
    logic [15:0] m0, m1, rm0, rm1, q0, q1, rq0, rq1;

    edge_timing_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .mon_clk_i(tck), .mon_dat_i(tdat),
        .viol_vld_o(v0), .viol_kind_o(k0), .viol_meas_o(m0), .viol_req_o(q0));

    edge_timing_monitor #(
        .WD_CLK(0), .WD_DAT(0), .SPIKE(0), .T_SETUP(0), .T_HOLD(75),
        .T_HIGH(0), .T_LOW(500)
    ) u_dut0 (
        .clk(clk), .rst_n(rst_n), .mon_clk_i(tck), .mon_dat_i(tdat),
        .viol_vld_o(v1), .viol_kind_o(k1), .viol_meas_o(m1), .viol_req_o(q1));

    tmon_ref #(.WD_C(20), .WD_D(10), .SP(5), .TSU(50), .THD(75), .THI(300), .TLO(500))
        u_ref (.clk(clk), .rst_n(rst_n), .ck_raw(tck), .dt_raw(tdat),
               .vld(rv0), .kind(rk0), .meas(rm0), .req(rq0));

    tmon_ref #(.WD_C(0), .WD_D(0), .SP(0), .TSU(0), .THD(75), .THI(0), .TLO(500))
        u_ref0 (.clk(clk), .rst_n(rst_n), .ck_raw(tck), .dt_raw(tdat),
                .vld(rv1), .kind(rk1), .meas(rm1), .req(rq1));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bad0 = 0;
    bit done = 0;
    int rep_k[$];
    int rep_m[$];
    int rep_r[$];
    int rep_t[$];

    task automatic check(input string rq, input bit ok, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model, plus report capture
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            check("R8", v0 == rv0 && (!rv0 || (k0 == rk0 && m0 == rm0 && q0 == rq0)),
                  "u_dut report {vld,kind,meas}", int'({v0, k0, m0}), int'({rv0, rk0, rm0}));
            check("R10", v1 == rv1 && (!rv1 || (k1 == rk1 && m1 == rm1 && q1 == rq1)),
                  "u_dut0 report {vld,kind,meas}", int'({v1, k1, m1}), int'({rv1, rk1, rm1}));
            if (v0) begin
                rep_k.push_back(int'(k0)); rep_m.push_back(int'(m0));
                rep_r.push_back(int'(q0)); rep_t.push_back(cyc);
            end
            if (v1 && (k1 == 3'd0 || k1 == 3'd2)) bad0++;
        end
    end

    task automatic expect_count(input string rq, input int nexp);
        check(rq, rep_k.size() == nexp, "report count", rep_k.size(), nexp);
    endtask

    task automatic expect_rep(input string rq, input int idx, input int k,
                              input int m, input int r);
        int ak = (idx < rep_k.size()) ? rep_k[idx] : -1;
        int am = (idx < rep_m.size()) ? rep_m[idx] : -1;
        int ar = (idx < rep_r.size()) ? rep_r[idx] : -1;
        check(rq, ak == k, "kind", ak, k);
        check(rq, am == m, "measured", am, m);
        check(rq, ar == r, "required", ar, r);
    endtask

    task automatic clear_reps();
        rep_k.delete(); rep_m.delete(); rep_r.delete(); rep_t.delete();
    endtask

    // one monitored clock period: hi ticks high then lo ticks low; data toggles
    // at index dpos (from the rise) and toggles back glen ticks later if glen > 0
    task automatic pulse(input int hi, input int lo, input int dpos, input int glen);
        for (int i = 0; i < hi + lo; i++) begin
            @(negedge clk);
            tck = (i < hi);
            if (i == dpos) tdat = ~tdat;
            if (glen > 0 && i == dpos + glen) tdat = ~tdat;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tck = 0;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R12: outputs held at zero in reset
        check("R12", v0 == 0 && m0 == 0 && k0 == 0, "u_dut outputs in reset", int'(v0), 0);
        check("R12", v1 == 0, "u_dut0 valid in reset", int'(v1), 0);
        rst_n = 1;
        idle(100);

        // Phase A, R12 and R4: clean periods, data moves just before and just after rises
        pulse(400, 600, 990, 0);
        pulse(400, 600, 5, 0);
        expect_count("R4", 0);
        clear_reps();

        // Phase B, R3 and R1: setup boundary (raw lead 40/39 -> internal 50/49)
        pulse(400, 600, 360, 0);
        pulse(400, 600, 361, 0);
        expect_count("R3", 1);
        expect_rep("R1", 0, 0, 49, 50);
        clear_reps();

        // Phase C, R5: hold boundary, then two changes in one window
        pulse(400, 600, 485, 0);
        pulse(400, 600, 484, 0);
        pulse(400, 600, 430, 20);
        expect_count("R5", 2);
        expect_rep("R5", 0, 1, 74, 75);
        expect_rep("R5", 1, 1, 20, 75);
        clear_reps();

        // Phase D, R6 and R7: width boundaries
        pulse(299, 600, -1, 0);
        pulse(300, 600, -1, 0);
        pulse(400, 499, -1, 0);
        pulse(400, 600, -1, 0);
        pulse(400, 500, -1, 0);
        pulse(400, 600, -1, 0);
        expect_count("R6", 2);
        expect_rep("R6", 0, 2, 299, 300);
        expect_rep("R7", 1, 3, 499, 500);
        clear_reps();

        // Phase E, R2: 3-tick data glitch before a fall, 4-tick clock spike in low phase
        pulse(400, 600, 380, 3);
        idle(300);
        for (int i = 0; i < 4; i++) begin @(negedge clk); tck = 1; end
        idle(300);
        pulse(400, 600, -1, 0);
        expect_count("R2", 0);
        clear_reps();

        // Phase F, R9: data change lands on the internal fall of a short high phase
        pulse(250, 600, 260, 0);
        expect_count("R9", 2);
        expect_rep("R9", 0, 0, 0, 50);
        expect_rep("R9", 1, 2, 250, 300);
        check("R9", rep_t.size() == 2 && rep_t[1] == rep_t[0] + 1, "report spacing",
              (rep_t.size() == 2) ? rep_t[1] - rep_t[0] : -1, 1);
        clear_reps();

        // Phase G, R11: low phase of 65636 ticks would wrap to 100 in 16 bits
        idle(65036);
        pulse(400, 600, -1, 0);
        expect_count("R11", 0);
        clear_reps();

        // R10: the instance with zero setup and high-width limits never reports those kinds
        check("R10", bad0 == 0, "disabled-kind reports on u_dut0", bad0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule